// File: doc/BRIEF.md
# Saturating Fractional ALU with Carry and Overflow Flags

This block performs one arithmetic or logic step on signed binary fractions. Each step takes a destination operand and a source operand. The source can be shifted left by up to two places before use. Operands are 25-bit two's-complement fractions with one sign bit and 24 fraction bits, so their legal range is -1.0 up to, but not including, +1.0. Internally both operands are widened to a 28-bit word that has four guard/sign bits above the binary point. This extra headroom lets the block see that a result has left the legal range. It then raises an overflow flag and, when limiting is in force for that operation, clamps the result to full scale.

Every operation has its own rule for the carry flag and for whether limiting applies. A condition-enable input changes the behaviour of some operations. It can turn a load into a no-operation when the tested converter bit is 0. It can switch limiting on for an exclusive-or and off for an absolute-add. A conditional subtract chooses between subtracting and adding from the prior carry. Inputs are sampled on the rising clock edge. The result and both flags are registered and appear one cycle later.

Top module: `fa_alu`

## Requirements
- R1: While rst_ni is low, result_o, carry_o and ovf_o are all 0.
- R2: op_i codes are 0 ADD, 1 SUB, 2 CSUB, 3 ABS, 4 ABA, 5 LDA, 6 AND, 7 XOR, 8 LIM. Both operands are sign-extended to 28 bits (bit 24 is the sign). The source is multiplied by 2^shift_i, and shift_i = 3 acts as 2. The results of inputs sampled at a rising edge appear on the outputs after that edge. result_o carries the low 25 bits of the 28-bit result.
- R3: ovf_o is 1 exactly when the true value falls outside the range -2^24..2^24-1 in 25-bit code units, so that bits 27..24 of the 28-bit result disagree. For LIM the test is applied to the shifted source.
- R4: ADD gives dst+src. Carry is 0 when both operand signs are positive and 1 when both are negative. With mixed signs, carry is 1 exactly when the result is non-negative. The result is limited only when lim_en_i is 1.
- R5: SUB gives dst-src, formed by inverting the source with carry-in 1. Carry is 1 when dst is negative and src is positive. Otherwise carry is 1 exactly when the result is non-negative. CSUB subtracts under the SUB rules when carry_i is 0, and adds under the ADD carry rules when carry_i is 1. Neither SUB nor CSUB is limited.
- R6: ABS gives |src| and LDA gives src. Both ignore dst, force carry to 0 and are always limited.
- R7: ABA gives dst+|src|. Carry is 0 when dst is positive and 1 when both are negative. When dst is negative and src positive, carry is 1 exactly when the result is non-negative. It is limited when lim_en_i is 1 and cond_i is 0.
- R8: AND and XOR act bitwise on the 28-bit operands. AND is never limited and gives carry 0. XOR gives carry 1 only when both signs are negative, and is limited when lim_en_i or cond_i is 1.
- R9: LIM outputs 0x0FFFFFF when the source sign is 0 and 0x1000000 when it is 1. It sets carry to 0.
- R10: A limited, overflowed result is replaced by 0x0FFFFFF when bit 27 of the 28-bit result is 0, and by 0x1000000 when it is 1.
- R11: LDA with cond_i=1 and conv_bit_i=0 is a no-operation, and so is any op_i code above 8. A no-operation gives result_o=dst_i, carry_o=carry_i and ovf_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation select |
| dst_i | input | 25 | Destination operand, signed fraction |
| src_i | input | 25 | Source operand, signed fraction |
| shift_i | input | 2 | Source left-shift amount (0..2) |
| cond_i | input | 1 | Condition-enable |
| carry_i | input | 1 | Prior carry flag |
| conv_bit_i | input | 1 | Tested converter bit |
| lim_en_i | input | 1 | Limiting enable for ADD, ABA, XOR |
| result_o | output | 25 | Registered result |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
The two functions that meet in one cycle are source shifting and saturation. A two-place left shift can push significant bits into the guard bits, so a single operation both overflows and is clamped. The bench provokes this with shifted sources on ADD, ABA, LDA, ABS and XOR, with limiting both on and off. It checks that ovf_o is raised in both cases and that result_o is clamped in the direction of the true sign only when limiting is in force. The expected values come from a wide-integer model written from the requirements.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CSUB = 4'd2,
    OP_ABS  = 4'd3,
    OP_ABA  = 4'd4,
    OP_LDA  = 4'd5,
    OP_AND  = 4'd6,
    OP_XOR  = 4'd7,
    OP_LIM  = 4'd8,
    OP_NOP  = 4'd15
  } fa_op_e;
endpackage

// File: rtl/fa_alu_operand.sv
module fa_alu_operand
  import fa_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int GUARD_W = 4,
  parameter int SHIFT_W = 2,
  localparam int DATA_W = FRAC_W + 1,
  localparam int EXT_W  = FRAC_W + GUARD_W
) (
  input  fa_op_e              op_i,
  input  logic [DATA_W-1:0]   dst_i,
  input  logic [DATA_W-1:0]   src_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic                carry_i,
  output logic [EXT_W-1:0]    a_o,
  output logic [EXT_W-1:0]    b_o,
  output logic                cin_o,
  output logic                negate_o
);
  // leftmost guard bit must still hold the original sign after shifting
  localparam int MAX_SHIFT = GUARD_W - 2;

  logic [SHIFT_W-1:0] sh_eff;
  logic [EXT_W-1:0]   src_x, src_sh;
  logic               src_neg;

  assign src_neg = src_i[FRAC_W];
  assign sh_eff  = (int'(shift_i) > MAX_SHIFT) ? SHIFT_W'(MAX_SHIFT) : shift_i;
  assign src_x   = {{(GUARD_W-1){src_i[FRAC_W]}}, src_i};
  assign src_sh  = src_x << sh_eff;

  always_comb begin
    unique case (op_i)
      OP_SUB:         negate_o = 1'b1;
      OP_CSUB:        negate_o = ~carry_i;
      OP_ABS, OP_ABA: negate_o = src_neg;
      default:        negate_o = 1'b0;
    endcase
  end

  assign a_o   = (op_i == OP_ABS || op_i == OP_LDA) ? '0
               : {{(GUARD_W-1){dst_i[FRAC_W]}}, dst_i};
  assign b_o   = negate_o ? ~src_sh : src_sh;
  assign cin_o = negate_o;
endmodule

// File: rtl/fa_alu_core.sv
module fa_alu_core
  import fa_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int GUARD_W = 4,
  localparam int EXT_W  = FRAC_W + GUARD_W
) (
  input  fa_op_e           op_i,
  input  logic [EXT_W-1:0] a_i,
  input  logic [EXT_W-1:0] b_i,
  input  logic             cin_i,
  input  logic             negate_i,
  input  logic             dst_neg_i,
  input  logic             src_neg_i,
  input  logic             carry_i,
  output logic [EXT_W-1:0] res_o,
  output logic             carry_o
);
  logic [EXT_W-1:0] sum;
  logic             pos, add_c, sub_c;

  assign sum = a_i + b_i + EXT_W'(cin_i);
  assign pos = ~sum[EXT_W-1];

  assign add_c = (dst_neg_i == src_neg_i) ? dst_neg_i : pos;
  assign sub_c = (dst_neg_i && !src_neg_i) ? 1'b1 : pos;

  always_comb begin
    res_o   = sum;
    carry_o = 1'b0;
    unique case (op_i)
      OP_ADD:  carry_o = add_c;
      OP_SUB:  carry_o = sub_c;
      OP_CSUB: carry_o = negate_i ? sub_c : add_c;
      OP_ABS,
      OP_LDA:  carry_o = 1'b0;
      OP_ABA:  carry_o = !dst_neg_i ? 1'b0 : (src_neg_i ? 1'b1 : pos);
      OP_AND:  res_o = a_i & b_i;
      OP_XOR: begin
        res_o   = a_i ^ b_i;
        carry_o = dst_neg_i & src_neg_i;
      end
      OP_LIM:  res_o = b_i;
      default: begin
        res_o   = a_i;
        carry_o = carry_i;
      end
    endcase
  end
endmodule

// File: rtl/fa_alu_limit.sv
module fa_alu_limit #(
  parameter int FRAC_W  = 24,
  parameter int GUARD_W = 4,
  localparam int DATA_W = FRAC_W + 1,
  localparam int EXT_W  = FRAC_W + GUARD_W
) (
  input  logic [EXT_W-1:0]  res_i,
  input  logic              lim_en_i,
  input  logic              force_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {FRAC_W{1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {FRAC_W{1'b0}}};

  logic [GUARD_W-1:0] guard;
  logic [DATA_W-1:0]  fs;

  assign guard = res_i[EXT_W-1:FRAC_W];
  assign ovf_o = ~((&guard) | ~(|guard));
  assign fs    = res_i[EXT_W-1] ? NEG_FS : POS_FS;
  assign res_o = (force_i || (ovf_o && lim_en_i)) ? fs : res_i[DATA_W-1:0];
endmodule

// File: rtl/fa_alu.sv
module fa_alu
  import fa_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int GUARD_W = 4,
  parameter int SHIFT_W = 2,
  localparam int DATA_W = FRAC_W + 1,
  localparam int EXT_W  = FRAC_W + GUARD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    op_i,
  input  logic [DATA_W-1:0]  dst_i,
  input  logic [DATA_W-1:0]  src_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               cond_i,
  input  logic               carry_i,
  input  logic               conv_bit_i,
  input  logic               lim_en_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o,
  output logic               ovf_o
);
  fa_op_e            op_eff;
  logic              lim_eff;
  logic [EXT_W-1:0]  a, b, res_ext;
  logic              cin, negate, c_next, ovf_next;
  logic [DATA_W-1:0] res_next;

  always_comb begin
    op_eff = fa_op_e'(op_i);
    if (op_i > OP_W'(OP_LIM)) op_eff = OP_NOP;
    if (op_i == OP_W'(OP_LDA) && cond_i && !conv_bit_i) op_eff = OP_NOP;
  end

  always_comb begin
    unique case (op_eff)
      OP_ABS, OP_LDA: lim_eff = 1'b1;
      OP_ADD:         lim_eff = lim_en_i;
      OP_ABA:         lim_eff = lim_en_i & ~cond_i;
      OP_XOR:         lim_eff = lim_en_i | cond_i;
      default:        lim_eff = 1'b0;
    endcase
  end

  fa_alu_operand #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .SHIFT_W(SHIFT_W)) u_operand (
    .op_i     (op_eff),
    .dst_i    (dst_i),
    .src_i    (src_i),
    .shift_i  (shift_i),
    .carry_i  (carry_i),
    .a_o      (a),
    .b_o      (b),
    .cin_o    (cin),
    .negate_o (negate)
  );

  fa_alu_core #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_core (
    .op_i      (op_eff),
    .a_i       (a),
    .b_i       (b),
    .cin_i     (cin),
    .negate_i  (negate),
    .dst_neg_i (dst_i[FRAC_W]),
    .src_neg_i (src_i[FRAC_W]),
    .carry_i   (carry_i),
    .res_o     (res_ext),
    .carry_o   (c_next)
  );

  fa_alu_limit #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_limit (
    .res_i    (res_ext),
    .lim_en_i (lim_eff),
    .force_i  (op_eff == OP_LIM),
    .res_o    (res_next),
    .ovf_o    (ovf_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_next;
      carry_o  <= c_next;
      ovf_o    <= ovf_next;
    end
  end
endmodule

// File: rtl/fa_alu_chk.sv
module fa_alu_chk
  import fa_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int SHIFT_W = 2,
  localparam int DATA_W = FRAC_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OP_W-1:0]    op_i,
  input logic [DATA_W-1:0]  dst_i,
  input logic [DATA_W-1:0]  src_i,
  input logic [SHIFT_W-1:0] shift_i,
  input logic               cond_i,
  input logic               carry_i,
  input logic               conv_bit_i,
  input logic               lim_en_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               carry_o,
  input logic               ovf_o
);
  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {FRAC_W{1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {FRAC_W{1'b0}}};

  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  assert_lim_full_scale_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_LIM)
    |-> !carry_o && result_o == ($past(src_i[FRAC_W]) ? NEG_FS : POS_FS));

  assert_abs_carry_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_ABS) |-> !carry_o);

  assert_add_same_sign_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_ADD) && $past(dst_i[FRAC_W]) == $past(src_i[FRAC_W])
    |-> carry_o == $past(dst_i[FRAC_W]));

  assert_cond_load_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_LDA) && $past(cond_i) && !$past(conv_bit_i)
    |-> result_o == $past(dst_i) && carry_o == $past(carry_i) && !ovf_o);

  assert_and_unshifted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_AND) && $past(shift_i) == '0
    |-> result_o == ($past(dst_i) & $past(src_i)) && !ovf_o && !carry_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(op_i) == OP_W'(OP_LDA) && $past(shift_i) == '0
    && !($past(cond_i) && !$past(conv_bit_i))
    |-> !ovf_o && result_o == $past(src_i));
endmodule

bind fa_alu fa_alu_chk #(.FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)) u_fa_alu_chk (.*);

// File: tb/fa_alu_test.sv
module fa_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [24:0] POS_FS = 25'h0FFFFFF;
  localparam logic [24:0] NEG_FS = 25'h1000000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [24:0] dst_i = '0, src_i = '0;
  logic [1:0]  shift_i = '0;
  logic        cond_i = 0, carry_i = 0, conv_bit_i = 0, lim_en_i = 0;
  logic [24:0] result_o;
  logic        carry_o, ovf_o;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fa_alu uut (.*);

  // wide-integer model written from the requirements
  function automatic logic [26:0] model(int op, logic [24:0] d, logic [24:0] s, int sh,
                                        bit cnd, bit cin, bit cb, bit lim);
    longint dv, sv, ssh, v;
    logic [27:0] d28, s28, t28;
    bit dn, sn, c, le, o;
    logic [24:0] r;
    if (sh > 2) sh = 2;
    if (op > 8 || (op == 5 && cnd && !cb)) return {d, cin, 1'b0};
    dn = d[24]; sn = s[24];
    dv = longint'($signed(d)); sv = longint'($signed(s));
    ssh = sv * (longint'(1) << sh);
    d28 = 28'(dv); s28 = 28'(ssh);
    le = 0; c = 0; v = 0;
    case (op)
      0: begin v = dv + ssh; c = (dn == sn) ? dn : (v >= 0); le = lim; end
      1: begin v = dv - ssh; c = (dn && !sn) ? 1 : (v >= 0); end
      2: if (cin) begin v = dv + ssh; c = (dn == sn) ? dn : (v >= 0); end
         else begin v = dv - ssh; c = (dn && !sn) ? 1 : (v >= 0); end
      3: begin v = (ssh < 0) ? -ssh : ssh; le = 1; end
      4: begin v = dv + ((ssh < 0) ? -ssh : ssh); c = !dn ? 0 : (sn ? 1 : (v >= 0)); le = lim && !cnd; end
      5: begin v = ssh; le = 1; end
      6: begin t28 = d28 & s28; v = longint'($signed(t28)); end
      7: begin t28 = d28 ^ s28; v = longint'($signed(t28)); c = dn && sn; le = lim || cnd; end
      default: begin v = ssh; end
    endcase
    o = (v < -(longint'(1) << 24)) || (v >= (longint'(1) << 24));
    r = v[24:0];
    if (op == 8) r = sn ? NEG_FS : POS_FS;
    else if (o && le) r = (v < 0) ? NEG_FS : POS_FS;
    return {r, c, o};
  endfunction

  task automatic check(string req, logic [24:0] er, logic ec, logic eo);
    checks++;
    if (result_o !== er || carry_o !== ec || ovf_o !== eo) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b o=%b, expected res=%h c=%b o=%b",
               req, result_o, carry_o, ovf_o, er, ec, eo);
    end
  endtask

  task automatic drive(int op, logic [24:0] d, logic [24:0] s, int sh,
                       bit cnd, bit cin, bit cb, bit lim);
    @(negedge clk_i);
    op_i = 4'(op); dst_i = d; src_i = s; shift_i = 2'(sh);
    cond_i = cnd; carry_i = cin; conv_bit_i = cb; lim_en_i = lim;
    @(posedge clk_i); #1;
  endtask

  task automatic run(string req, int op, logic [24:0] d, logic [24:0] s, int sh,
                     bit cnd, bit cin, bit cb, bit lim);
    logic [26:0] e;
    drive(op, d, s, sh, cnd, cin, cb, lim);
    e = model(op, d, s, sh, cnd, cin, cb, lim);
    check(req, e[26:2], e[1], e[0]);
  endtask

  task automatic t_reset();
    rst_ni = 0; op_i = 4'd5; src_i = 25'h0ABCDEF;
    repeat (2) @(posedge clk_i);
    #1 check("R1 reset", '0, 1'b0, 1'b0);
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_add();
    drive(0, 25'h0C00000, 25'h0800000, 0, 0, 0, 0, 1);
    check("R4 R10 add clamp", POS_FS, 1'b0, 1'b1);
    drive(0, 25'h0C00000, 25'h0800000, 0, 0, 0, 0, 0);
    check("R4 add unlimited wrap", 25'h1400000, 1'b0, 1'b1);
    drive(0, 25'h1400000, 25'h1800000, 0, 0, 0, 0, 1);
    check("R4 R10 add neg clamp", NEG_FS, 1'b1, 1'b1);
    run("R4 mixed", 0, 25'h1C00000, 25'h0800000, 0, 0, 0, 0, 1);
    run("R4 mixed neg", 0, 25'h0200000, 25'h1800000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sub();
    run("R5 sub", 1, 25'h0400000, 25'h0800000, 0, 0, 0, 0, 1);
    run("R5 sub neg-pos", 1, 25'h1800000, 25'h0600000, 0, 0, 0, 0, 1);
    run("R5 sub no limit", 1, 25'h1000000, 25'h0400000, 1, 0, 0, 0, 1);
    drive(2, 25'h0800000, 25'h0200000, 0, 0, 0, 0, 0);
    check("R5 csub subtract", 25'h0600000, 1'b1, 1'b0);
    drive(2, 25'h0800000, 25'h0200000, 0, 0, 1, 0, 0);
    check("R5 csub add", 25'h0A00000, 1'b0, 1'b0);
  endtask

  task automatic t_abs_lda();
    drive(3, 25'h0123456, 25'h1000000, 0, 0, 1, 0, 0);
    check("R6 R10 abs of -1.0", POS_FS, 1'b0, 1'b1);
    run("R6 abs neg", 3, 25'h0FFFFFF, 25'h1C00000, 0, 0, 1, 0, 0);
    drive(5, 25'h1111111, 25'h0600000, 2, 0, 1, 1, 0);
    check("R6 R2 lda shift clamp", POS_FS, 1'b0, 1'b1);
    drive(5, 25'h1111111, 25'h1E00000, 3, 0, 1, 1, 0);
    check("R2 shift 3 as 2", 25'h1800000, 1'b0, 1'b0);
  endtask

  task automatic t_aba();
    run("R7 aba pos neg", 4, 25'h0200000, 25'h1C00000, 0, 0, 0, 0, 1);
    run("R7 aba neg pos", 4, 25'h1800000, 25'h0400000, 1, 0, 0, 0, 1);
    drive(4, 25'h0C00000, 25'h1800000, 0, 1, 0, 0, 1);
    check("R7 cond aba unlimited", 25'h1400000, 1'b0, 1'b1);
    run("R7 aba clamp", 4, 25'h0C00000, 25'h1800000, 0, 0, 0, 0, 1);
  endtask

  task automatic t_logic();
    run("R8 and shifted", 6, 25'h1F0F0F0, 25'h0700000, 2, 0, 1, 0, 1);
    drive(7, 25'h1000000, 25'h1800000, 0, 0, 0, 0, 0);
    check("R8 xor neg neg", 25'h0800000, 1'b1, 1'b0);
    run("R8 xor shift unlimited", 7, 25'h0000000, 25'h0600000, 2, 0, 0, 0, 0);
    run("R8 xor cond limits", 7, 25'h0000000, 25'h0600000, 2, 1, 0, 0, 0);
  endtask

  task automatic t_lim();
    drive(8, 25'h0555555, 25'h1FFFFFF, 0, 0, 1, 0, 0);
    check("R9 lim neg", NEG_FS, 1'b0, 1'b0);
    drive(8, 25'h1555555, 25'h0000001, 0, 0, 1, 0, 0);
    check("R9 lim pos", POS_FS, 1'b0, 1'b0);
    drive(8, 25'h0, 25'h0600000, 2, 0, 1, 0, 0);
    check("R9 R3 lim shifted ovf", POS_FS, 1'b0, 1'b1);
  endtask

  task automatic t_noop();
    drive(5, 25'h1234567, 25'h0400000, 2, 1, 1, 0, 1);
    check("R11 cond lda noop", 25'h1234567, 1'b1, 1'b0);
    drive(5, 25'h1234567, 25'h0400000, 0, 1, 0, 1, 1);
    check("R11 cond lda taken", 25'h0400000, 1'b0, 1'b0);
    drive(12, 25'h0ABCDEF, 25'h1000000, 2, 0, 0, 1, 1);
    check("R11 unused code", 25'h0ABCDEF, 1'b0, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 600; i++) begin
      logic [24:0] d, s;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      d = seed[24:0];
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      s = seed[24:0];
      if (seed[25]) s = {s[24], {2{s[24]}}, s[21:0]};
      run("R2 R3 sweep", i % 10, d, s, int'(seed[27:26]), seed[28], seed[29], seed[30], seed[31]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_abs_lda();
    t_aba();
    t_logic();
    t_lim();
    t_noop();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule